// File: doc/BRIEF.md
# Indexed Color Palette with Sequenced Component Loading

This block holds a 256-entry color table. Each entry has an 8-bit red, green and blue component. Software loads the table through a small byte-addressed register bus with two locations. The first location is a pointer that selects a table entry. The second is a data port. Bytes written to the data port fill the selected entry one component at a time, in the order red, green, blue. After the blue component is stored, the pointer moves to the next entry on its own.

A 32-bit write to the data port is taken as four byte steps in one bus cycle, most significant byte first. Such a write can finish one entry and begin the next. Every write to the data port produces a one-cycle notification pulse, so that downstream display logic can schedule a full refresh.

On the pixel side, an 8-bit pixel code is converted to a 24-bit color through a registered lookup. Bus accesses complete in one cycle with no wait states.

Top module: `pal_dac`

## Requirements
- R1: Reads return zero at both bus locations: `bus_rdata` is 0 when `bus_addr` is 0x0 (pointer) or 0x4 (data port).
- R2: A write to offset 0x0 loads `bus_wdata[7:0]` into the entry pointer and sets the component phase to red, whatever the phase was before.
- R3: Each byte step at offset 0x4 stores its byte into the component selected by the current phase (red, then green, then blue, then red again) of the entry under the pointer. A byte write (`bus_size`=0) is one step and uses `bus_wdata[7:0]`.
- R4: The step that stores blue advances the pointer by one, modulo 256, so entry 255 is followed by entry 0.
- R5: A word write (`bus_size`=1) at offset 0x4 performs four steps in the same cycle. The bytes are taken in the order `bus_wdata[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, and the phase and pointer carry across the steps.
- R6: While `rst_n` is low, every component of every entry is zero, the phase is red, the pointer is 0 and `rgb_out` is 0.
- R7: The color for the `pix_in` value present at a rising edge appears on `rgb_out` after that edge, packed as red in bits 23:16, green in 15:8 and blue in 7:0.
- R8: When a data-port write and a lookup of the same entry occur in the same cycle, the lookup returns the value the entry held before the write.
- R9: `pal_changed` is high for exactly the one cycle after each data-port write, whether byte or word. It stays low after pointer writes and after idle cycles.
- R10: A write to any offset other than 0x0 or 0x4 changes no entry, no pointer, no phase and does not pulse `pal_changed`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 5 | Byte offset of the access |
| bus_size | input | 1 | 0 = byte write, 1 = 32-bit write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| pix_in | input | 8 | Pixel code to convert |
| rgb_out | output | 24 | Registered color for the pixel code |
| pal_changed | output | 1 | One-cycle pulse after each data-port write |

## Verification
A bus write takes effect at the rising edge where `bus_wr` is sampled. The bench drives each access at a falling edge and reads back `pal_changed` at the next falling edge, which is half a cycle after that rising edge. A lookup result appears one edge after `pix_in` is applied, so every color check drives `pix_in` at a falling edge and compares `rgb_out` one full cycle later. Any write must reach the table at least one edge before the lookup is sampled, except in the collision test, where the old value is expected. The pointer and phase have no port, so their state is checked through the entries that later writes land in.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int COMP_W  = 8;
  localparam int N_COMP  = 3;
  localparam int COLOR_W = COMP_W * N_COMP;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_RED:  next_phase = PH_GRN;
      PH_GRN:  next_phase = PH_BLU;
      default: next_phase = PH_RED;
    endcase
  endfunction
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int OFS_IDX  = 0,
  parameter int OFS_DATA = 4,
  localparam int STEPS   = DATA_W / COMP_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_size,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [STEPS-1:0]               step_vld,
  output logic [STEPS-1:0][1:0]          step_comp,
  output logic [STEPS-1:0][IDX_W-1:0]    step_idx,
  output logic [STEPS-1:0][COMP_W-1:0]   step_byte,
  output logic [IDX_W-1:0]               index_q,
  output phase_e                         phase_q,
  output logic                           changed_q
);
  logic       idx_wr, data_wr;
  logic [IDX_W-1:0] index_d, ix_w;
  phase_e     phase_d, ph_w;
  logic       seq_en;

  assign idx_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_IDX));
  assign data_wr = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign seq_en  = idx_wr || data_wr;

  // walk the steps of this access, carrying phase and pointer across them
  always_comb begin
    ph_w = phase_q;
    ix_w = index_q;
    for (int s = 0; s < STEPS; s++) begin
      step_vld[s]  = data_wr && (bus_size || (s == 0));
      step_comp[s] = ph_w;
      step_idx[s]  = ix_w;
      step_byte[s] = bus_size ? bus_wdata[DATA_W-1-COMP_W*s -: COMP_W]
                              : bus_wdata[COMP_W-1:0];
      if (step_vld[s]) begin
        if (ph_w == PH_BLU) ix_w = ix_w + 1'b1;
        ph_w = next_phase(ph_w);
      end
    end
  end

  always_comb begin
    if (idx_wr) begin
      index_d = bus_wdata[IDX_W-1:0];
      phase_d = PH_RED;
    end else begin
      index_d = ix_w;
      phase_d = ph_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      phase_q <= PH_RED;
    end else if (seq_en) begin
      index_q <= index_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) changed_q <= 1'b0;
    else        changed_q <= data_wr;
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int STEPS   = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [STEPS-1:0]              step_vld,
  input  logic [STEPS-1:0][1:0]         step_comp,
  input  logic [STEPS-1:0][IDX_W-1:0]   step_idx,
  input  logic [STEPS-1:0][COMP_W-1:0]  step_byte,
  output logic [ENTRIES-1:0][COLOR_W-1:0] entry_q
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    for (genvar c = 0; c < N_COMP; c++) begin : g_cmp
      logic              we;
      logic [COMP_W-1:0] d;
      logic [COMP_W-1:0] q;

      always_comb begin
        we = 1'b0;
        d  = '0;
        for (int s = 0; s < STEPS; s++) begin
          if (step_vld[s] && (step_idx[s] == IDX_W'(e)) && (step_comp[s] == 2'(c))) begin
            we = 1'b1;
            d  = step_byte[s];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
      end

      // red in the top byte, blue in the bottom byte
      assign entry_q[e][(N_COMP-1-c)*COMP_W +: COMP_W] = q;
    end
  end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [IDX_W-1:0]                pix_in,
  input  logic [ENTRIES-1:0][COLOR_W-1:0] entry_q,
  output logic [COLOR_W-1:0]              rgb_q
);
  logic [COLOR_W-1:0] rgb_d;

  always_comb rgb_d = entry_q[pix_in];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= rgb_d;
  end
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int STEPS   = DATA_W / COMP_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_size,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [IDX_W-1:0]   pix_in,
  output logic [COLOR_W-1:0] rgb_out,
  output logic               pal_changed
);
  logic [STEPS-1:0]               step_vld;
  logic [STEPS-1:0][1:0]          step_comp;
  logic [STEPS-1:0][IDX_W-1:0]    step_idx;
  logic [STEPS-1:0][COMP_W-1:0]   step_byte;
  logic [IDX_W-1:0]               index_q;
  phase_e                         phase_q;
  logic [ENTRIES-1:0][COLOR_W-1:0] entry_q;

  assign bus_rdata = '0;

  pal_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .step_vld(step_vld), .step_comp(step_comp), .step_idx(step_idx),
    .step_byte(step_byte), .index_q(index_q), .phase_q(phase_q),
    .changed_q(pal_changed)
  );

  pal_store #(.IDX_W(IDX_W), .STEPS(STEPS)) u_store (
    .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .step_comp(step_comp),
    .step_idx(step_idx), .step_byte(step_byte), .entry_q(entry_q)
  );

  pal_lookup #(.IDX_W(IDX_W)) u_look (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .entry_q(entry_q),
    .rgb_q(rgb_out)
  );
endmodule

// File: rtl/pal_dac_checker.sv
module pal_dac_checker #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [IDX_W-1:0]  pix_in,
  input logic [23:0]       rgb_out,
  input logic              pal_changed,
  input logic [IDX_W-1:0]  index_q,
  input logic [1:0]        phase_q
);
  function automatic logic [1:0] nxt(input logic [1:0] p);
    nxt = (p == 2'd2) ? 2'd0 : p + 2'd1;
  endfunction

  logic idx_wr, data_wr, other_wr;
  assign idx_wr   = bus_wr && (bus_addr == ADDR_W'(0));
  assign data_wr  = bus_wr && (bus_addr == ADDR_W'(4));
  assign other_wr = bus_wr && !idx_wr && !data_wr;

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (index_q == $past(bus_wdata[IDX_W-1:0])) && (phase_q == 2'd0)); // R2

  AST_BYTE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !bus_size) |=> phase_q == nxt($past(phase_q))); // R3

  AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !bus_size && phase_q == 2'd2) |=> index_q == IDX_W'($past(index_q) + 1'b1)); // R4

  AST_WORD_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && bus_size) |=> (phase_q == nxt($past(phase_q))) &&
      (index_q == IDX_W'($past(index_q) + (($past(phase_q) == 2'd2) ? 2 : 1)))); // R5

  AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!data_wr) && $stable(pix_in)) |=> $stable(rgb_out)); // R7

  AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> pal_changed); // R9

  AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !pal_changed); // R9

  AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> $stable(index_q) && $stable(phase_q)); // R10
endmodule

bind pal_dac pal_dac_checker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .pix_in(pix_in),
  .rgb_out(rgb_out), .pal_changed(pal_changed), .index_q(index_q),
  .phase_q(phase_q)
);

// File: tb/pal_dac_bench.sv
module pal_dac_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic        bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_in;
  logic [23:0] rgb_out;
  logic        pal_changed;

  int n_run  = 0;
  int n_fail = 0;

  logic [7:0] r_m [256];
  logic [7:0] g_m [256];
  logic [7:0] b_m [256];
  logic [7:0] idx_m;
  int         ph_m;

  pal_dac u_pal_dac (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_in(pix_in), .rgb_out(rgb_out), .pal_changed(pal_changed)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_rgb(input logic [7:0] p);
    exp_rgb = {r_m[p], g_m[p], b_m[p]};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 256; i++) begin
      r_m[i] = 8'h00; g_m[i] = 8'h00; b_m[i] = 8'h00;
    end
    idx_m = 8'h00;
    ph_m  = 0;
  endtask

  task automatic model_step(input logic [7:0] v);
    case (ph_m)
      0: begin r_m[idx_m] = v; ph_m = 1; end
      1: begin g_m[idx_m] = v; ph_m = 2; end
      default: begin b_m[idx_m] = v; idx_m = idx_m + 8'd1; ph_m = 0; end
    endcase
  endtask

  // drive at a falling edge, commit at the rising edge, observe at the next falling edge
  task automatic bus_write(input logic [4:0] a, input logic sz, input logic [31:0] d,
                           input string req);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    if (a == 5'd0) begin
      idx_m = d[7:0]; ph_m = 0;
    end else if (a == 5'd4) begin
      if (sz) begin
        model_step(d[31:24]); model_step(d[23:16]);
        model_step(d[15:8]);  model_step(d[7:0]);
      end else begin
        model_step(d[7:0]);
      end
    end
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 5'd4) check(pal_changed == 1'b1, {"R9 ", req}, 32'(pal_changed), 32'd1);
    else           check(pal_changed == 1'b0, {"R9 ", req}, 32'(pal_changed), 32'd0);
  endtask

  task automatic lookup(input logic [7:0] p, input string req);
    @(negedge clk);
    pix_in = p;
    @(negedge clk);
    check(rgb_out == exp_rgb(p), req, 32'(rgb_out), 32'(exp_rgb(p)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rnd;
    void'($urandom(32'd20240517));
    bus_wr = 1'b0; bus_addr = '0; bus_size = 1'b0; bus_wdata = '0; pix_in = '0;
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check(rgb_out == 24'h0, "R6 rgb during reset", 32'(rgb_out), 32'h0);
    check(pal_changed == 1'b0, "R6 changed during reset", 32'(pal_changed), 32'h0);
    rst_n = 1'b1;

    // R1: reads return zero at both locations
    @(negedge clk); bus_addr = 5'd0;
    #1 check(bus_rdata == 32'h0, "R1 read pointer", bus_rdata, 32'h0);
    bus_addr = 5'd4;
    #1 check(bus_rdata == 32'h0, "R1 read data port", bus_rdata, 32'h0);

    // R6: table empty after reset, first byte goes to red of entry 0
    lookup(8'd0, "R6 entry 0 after reset");
    lookup(8'd255, "R6 entry 255 after reset");
    bus_write(5'd4, 1'b0, 32'h0000_00A5, "first byte after reset");
    lookup(8'd0, "R6 reset phase red pointer 0");

    // R3: byte sequence red, green, blue, then pointer advances (R4)
    bus_write(5'd0, 1'b0, 32'h0000_0010, "pointer write");
    bus_write(5'd4, 1'b0, 32'h0000_0011, "byte r");
    bus_write(5'd4, 1'b0, 32'h0000_0022, "byte g");
    bus_write(5'd4, 1'b0, 32'h0000_0033, "byte b");
    bus_write(5'd4, 1'b0, 32'h0000_0044, "byte next r");
    lookup(8'h10, "R3 entry 0x10 filled in order");
    lookup(8'h11, "R4 pointer advanced after blue");

    // R2: pointer write in mid-entry resets phase to red
    bus_write(5'd0, 1'b0, 32'hFFFF_FF20, "pointer write upper bits");
    bus_write(5'd4, 1'b0, 32'h0000_0055, "byte r");
    bus_write(5'd4, 1'b0, 32'h0000_0066, "byte g");
    bus_write(5'd0, 1'b0, 32'h0000_0020, "pointer rewrite");
    bus_write(5'd4, 1'b0, 32'h0000_0077, "byte r again");
    lookup(8'h20, "R2 phase back to red");

    // R4: wrap from 255 to 0
    bus_write(5'd0, 1'b0, 32'h0000_00FF, "pointer 255");
    bus_write(5'd4, 1'b1, 32'h0102_0399, "word wraps");
    lookup(8'hFF, "R4 entry 255");
    lookup(8'h00, "R4 wrap to entry 0");

    // R5: word writes starting at each phase
    bus_write(5'd0, 1'b0, 32'h0000_0040, "pointer 0x40");
    bus_write(5'd4, 1'b1, 32'h1122_3344, "word from red");
    bus_write(5'd4, 1'b1, 32'h5566_7788, "word from green");
    bus_write(5'd4, 1'b1, 32'h99AA_BBCC, "word from blue");
    lookup(8'h40, "R5 word entry 0x40");
    lookup(8'h41, "R5 word entry 0x41");
    lookup(8'h42, "R5 word entry 0x42");
    lookup(8'h43, "R5 word entry 0x43");

    // R10: other offsets ignored
    bus_write(5'd0, 1'b0, 32'h0000_0050, "pointer 0x50");
    bus_write(5'd8, 1'b1, 32'hDEAD_BEEF, "ignored offset 8");
    bus_write(5'd5, 1'b0, 32'h0000_00EE, "ignored offset 5");
    bus_write(5'd4, 1'b0, 32'h0000_0012, "byte after ignored");
    lookup(8'h50, "R10 ignored writes left pointer and phase");
    lookup(8'h51, "R10 no entry touched");

    // R9: pulse lasts one cycle
    bus_write(5'd4, 1'b0, 32'h0000_0034, "byte g");
    @(negedge clk);
    check(pal_changed == 1'b0, "R9 pulse one cycle", 32'(pal_changed), 32'h0);

    // R8: same-cycle write and lookup give the old value
    @(negedge clk);
    pix_in = idx_m;
    begin
      logic [23:0] old_v;
      logic [7:0]  hit;
      hit = idx_m;
      old_v = exp_rgb(hit);
      bus_wr = 1'b1; bus_addr = 5'd4; bus_size = 1'b0; bus_wdata = 32'h0000_00C3;
      @(posedge clk);
      model_step(8'hC3);
      @(negedge clk);
      bus_wr = 1'b0;
      check(rgb_out == old_v, "R8 collision returns old", 32'(rgb_out), 32'(old_v));
      @(negedge clk);
      check(rgb_out == exp_rgb(hit), "R8 new value next cycle", 32'(rgb_out), 32'(exp_rgb(hit)));
    end

    // random mix of accesses checked against the model (R3 R5 R7)
    for (int k = 0; k < 400; k++) begin
      rnd = $urandom();
      case (rnd[2:0])
        3'd0:    bus_write(5'd0, 1'b0, $urandom(), "rand pointer");
        3'd1, 3'd2, 3'd3: bus_write(5'd4, 1'b0, $urandom(), "rand byte");
        3'd4, 3'd5: bus_write(5'd4, 1'b1, $urandom(), "rand word");
        3'd6:    bus_write(5'(5'd8 + rnd[5:3]), rnd[6], $urandom(), "rand ignored");
        default: lookup(8'($urandom()), "R7 random lookup");
      endcase
      if (rnd[9:8] == 2'd0) lookup(idx_m, "R7 lookup at pointer");
    end
    for (int p = 0; p < 256; p += 17) lookup(8'(p), "R7 sweep");

    // R6: reset in mid-run clears the whole table
    @(negedge clk); rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    check(rgb_out == 24'h0, "R6 rgb cleared by reset", 32'(rgb_out), 32'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 256; p++) lookup(8'(p), "R6 table cleared");
    bus_write(5'd4, 1'b1, 32'hA1B2_C3D4, "word after reset");
    lookup(8'd0, "R6 pointer 0 phase red after reset");
    lookup(8'd1, "R6 spill into entry 1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule